// File: doc/BRIEF.md
# Pipelined Rectangular-to-Polar Converter

This block takes a stream of signed Cartesian samples `(x, y)` and returns the length and direction of each vector. It is built as an unrolled CORDIC in vectoring mode. Each fine-rotation stage is a fixed shift-and-add element, so the block accepts a new sample on every clock and returns one result per clock. Every result appears a fixed number of cycles after its sample.

The pipeline has three parts. A front end mirrors any left-half-plane vector about the y-axis by taking `|x|`, and records that it did so. A chain of `STAGES` fine-rotation elements drives `y` toward zero and accumulates the fine angle. A back end restores the true half-plane of the angle and scales the magnitude by 1/K. The CORDIC gain is removed only at this final step.

The inputs are Q(IN_W-8).8 values. The magnitude uses the same 8 fractional bits. The angle is a signed `ANG_W`-bit fraction of a full turn.

Top module: `rect2polar`

## Requirements
- R1: While `rst_ni` is low at a clock edge, the block clears its registers. After that edge `vld_o`, `mag_o` and `ang_o` read 0.
- R2: A sample taken with `vld_i` high appears on the outputs with `vld_o` high exactly `STAGES+2` clock edges later. Back-to-back samples come out back to back, in order.
- R3: For an input with x < 0, the angle is the half-turn code minus the fine angle of the mirrored vector. With the wrap of the `ANG_W`-bit code, quadrant-2 inputs give angles near +180° and quadrant-3 inputs give angles near −180°.
- R4: `mag_o` equals sqrt(x²+y²) in the input's fixed-point units to within 3 LSB. The gain is removed by a shift-add multiply by 1/K and rounded.
- R5: `ang_o` equals atan2(y, x)·2^ANG_W/(2π), compared modulo 2^ANG_W. The tolerance is 4 LSB plus 2^(ANG_W+1)/(2π·|v|), where |v| is the vector length in input LSB.
- R6: `mag_o` never exceeds 3·2^(IN_W−2). This holds for every input, including (−2^(IN_W−1), −2^(IN_W−1)).
- R7: The input (0, 0) yields `mag_o` = 0 and `ang_o` = 0.
- R8: Inputs on the axes give the axis angles within the R5 tolerance:
  - (0, +y) gives +90°, code 2^(ANG_W−2).
  - (0, −y) gives −90°, code −2^(ANG_W−2).
  - (−x, 0) gives the code −2^(ANG_W−1).
  - (+x, 0) gives 0.
- R9: A cycle with `vld_i` low produces no result, whatever `x_i` and `y_i` hold. The number of results equals the number of accepted samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, sampled on the clock edge |
| vld_i | input | 1 | Sample valid |
| x_i | input | IN_W | Signed x coordinate, 8 fractional bits |
| y_i | input | IN_W | Signed y coordinate, 8 fractional bits |
| vld_o | output | 1 | Result valid |
| mag_o | output | IN_W+1 | Unsigned magnitude, 8 fractional bits |
| ang_o | output | ANG_W | Signed angle; −2^(ANG_W−1) is −180° |

## Verification
In a back-to-back stream, the half-plane correction of one sample and the zero-vector override of the next sample act on adjacent results. The fold of a newly accepted left-half-plane sample can also fall in the same cycle as the reflection of an older sample leaving the back end.

The bench provokes both. It sends directed bursts with no gaps that alternate (0, 0) with quadrant-2 and quadrant-3 inputs. It then sends long random bursts, both dense and with gaps. Each result is matched in order against its own sample using real atan2 and square root. Its arrival cycle is checked against the fixed latency, so a reflection or zero flag that leaks to a neighbouring sample shows up as a wrong angle.

// File: rtl/rp_pkg.sv
package rp_pkg;

  typedef struct packed {
    logic flip;   // x was negative, vector mirrored about the y-axis
    logic zero;   // input was (0,0)
  } rp_tag_t;

  // 1/K with K = 1.646760, as an unsigned Q0.16 constant
  localparam int KINV_FRAC = 16;
  localparam logic [KINV_FRAC-1:0] KINV_Q = 16'd39797;

  // atan(2^-i) as a fraction of a full turn, scaled to 2^32
  function automatic logic [31:0] atan_turn32(input int idx);
    case (idx)
      0:  return 32'd536870912;
      1:  return 32'd316933406;
      2:  return 32'd167458907;
      3:  return 32'd85004756;
      4:  return 32'd42667331;
      5:  return 32'd21354465;
      6:  return 32'd10679838;
      7:  return 32'd5340245;
      8:  return 32'd2670163;
      9:  return 32'd1335087;
      10: return 32'd667544;
      11: return 32'd333772;
      12: return 32'd166886;
      13: return 32'd83443;
      14: return 32'd41722;
      15: return 32'd20861;
      16: return 32'd10430;
      17: return 32'd5215;
      18: return 32'd2608;
      19: return 32'd1304;
      20: return 32'd652;
      21: return 32'd326;
      22: return 32'd163;
      23: return 32'd81;
      24: return 32'd41;
      25: return 32'd20;
      26: return 32'd10;
      27: return 32'd5;
      28: return 32'd3;
      29: return 32'd1;
      30: return 32'd1;
      default: return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/rp_fold.sv
module rp_fold
  import rp_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int D_W   = 23,
  parameter int LSB_G = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   vld_i,
  input  logic signed [IN_W-1:0] x_i,
  input  logic signed [IN_W-1:0] y_i,
  output logic                   vld_o,
  output logic signed [D_W-1:0]  x_o,
  output logic signed [D_W-1:0]  y_o,
  output rp_tag_t                tag_o
);

  logic signed [D_W-1:0] x_ext, y_ext;
  assign x_ext = D_W'(x_i) <<< LSB_G;
  assign y_ext = D_W'(y_i) <<< LSB_G;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      x_o   <= '0;
      y_o   <= '0;
      tag_o <= '0;
    end else begin
      vld_o      <= vld_i;
      x_o        <= x_i[IN_W-1] ? -x_ext : x_ext;
      y_o        <= y_ext;
      tag_o.flip <= x_i[IN_W-1];
      tag_o.zero <= (x_i == '0) && (y_i == '0);
    end
  end

  assert_fold_right_half_R3: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> !x_o[D_W-1]
  ) else $error("folded x negative");

endmodule

// File: rtl/rp_stage.sv
module rp_stage
  import rp_pkg::*;
#(
  parameter int D_W = 23,
  parameter int Z_W = 20,
  parameter int IDX = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vld_i,
  input  logic signed [D_W-1:0] x_i,
  input  logic signed [D_W-1:0] y_i,
  input  logic signed [Z_W-1:0] z_i,
  input  rp_tag_t               tag_i,
  output logic                  vld_o,
  output logic signed [D_W-1:0] x_o,
  output logic signed [D_W-1:0] y_o,
  output logic signed [Z_W-1:0] z_o,
  output rp_tag_t               tag_o
);

  localparam int          SH    = 32 - Z_W;
  localparam logic [31:0] TURN  = atan_turn32(IDX);
  localparam logic [31:0] TRND  = (TURN + (32'd1 << (SH - 1))) >> SH;
  localparam logic signed [Z_W-1:0] ALPHA = TRND[Z_W-1:0];

  // constant shifts: pure wiring
  logic signed [D_W-1:0] x_sh, y_sh;
  assign x_sh = x_i >>> IDX;
  assign y_sh = y_i >>> IDX;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      x_o   <= '0;
      y_o   <= '0;
      z_o   <= '0;
      tag_o <= '0;
    end else begin
      vld_o <= vld_i;
      tag_o <= tag_i;
      if (!y_i[D_W-1]) begin  // y >= 0: rotate clockwise
        x_o <= x_i + y_sh;
        y_o <= y_i - x_sh;
        z_o <= z_i + ALPHA;
      end else begin
        x_o <= x_i - y_sh;
        y_o <= y_i + x_sh;
        z_o <= z_i - ALPHA;
      end
    end
  end

  assert_x_grows_R4: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (x_o >= $past(x_i))
  ) else $error("x shrank in stage %0d", IDX);

endmodule

// File: rtl/rp_finish.sv
module rp_finish
  import rp_pkg::*;
#(
  parameter int D_W   = 23,
  parameter int Z_W   = 20,
  parameter int ANG_W = 16,
  parameter int MAG_W = 17,
  parameter int LSB_G = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic signed [D_W-1:0]   x_i,
  input  logic signed [D_W-1:0]   y_i,
  input  logic signed [Z_W-1:0]   z_i,
  input  rp_tag_t                 tag_i,
  output logic                    vld_o,
  output logic [MAG_W-1:0]        mag_o,
  output logic signed [ANG_W-1:0] ang_o
);

  localparam int ZG  = Z_W - ANG_W;
  localparam int P_W = D_W + KINV_FRAC;
  localparam int RS  = KINV_FRAC + LSB_G;
  localparam logic signed [ANG_W-1:0] HALF_TURN = {1'b1, {(ANG_W-1){1'b0}}};
  localparam logic [MAG_W-1:0]        MAG_LIM   = MAG_W'(3) << (MAG_W - 3);

  logic [P_W-1:0] prod, prod_rnd;
  always_comb begin
    prod = '0;
    for (int b = 0; b < KINV_FRAC; b++)
      if (KINV_Q[b]) prod = prod + ({{KINV_FRAC{1'b0}}, x_i} << b);
  end
  assign prod_rnd = prod + (P_W'(1) << (RS - 1));

  logic signed [Z_W-1:0]   z_rnd;
  logic signed [ANG_W-1:0] fine;
  assign z_rnd = z_i + (Z_W'(1) << (ZG - 1));
  assign fine  = ANG_W'(z_rnd >>> ZG);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      mag_o <= '0;
      ang_o <= '0;
    end else begin
      vld_o <= vld_i;
      mag_o <= MAG_W'(prod_rnd >> RS);
      // +180 - fine and -180 - fine share one code after wrap
      if (tag_i.zero)      ang_o <= '0;
      else if (tag_i.flip) ang_o <= HALF_TURN - fine;
      else                 ang_o <= fine;
    end
  end

  assert_residual_bounded_R4: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    vld_i |-> ((y_i[D_W-1] ? -y_i : y_i) <= x_i + D_W'(1))
  ) else $error("residual y exceeds x");

  assert_mag_range_R6: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (mag_o <= MAG_LIM)
  ) else $error("magnitude out of range");

endmodule

// File: rtl/rect2polar.sv
module rect2polar
  import rp_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int STAGES = 16,
  parameter int ANG_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic signed [IN_W-1:0]  x_i,
  input  logic signed [IN_W-1:0]  y_i,
  output logic                    vld_o,
  output logic [IN_W:0]           mag_o,
  output logic signed [ANG_W-1:0] ang_o
);

  localparam int LSB_G = 4;
  localparam int D_W   = IN_W + 3 + LSB_G;
  localparam int Z_W   = ANG_W + 4;
  localparam int MAG_W = IN_W + 1;
  localparam int LAT   = STAGES + 2;
  localparam int CNT_W = $clog2(LAT + 1) + 1;

  logic                  vld_s [STAGES+1];
  logic signed [D_W-1:0] x_s   [STAGES+1];
  logic signed [D_W-1:0] y_s   [STAGES+1];
  logic signed [Z_W-1:0] z_s   [STAGES+1];
  rp_tag_t               tag_s [STAGES+1];

  rp_fold #(.IN_W(IN_W), .D_W(D_W), .LSB_G(LSB_G)) i_fold (
    .clk_i, .rst_ni, .vld_i, .x_i, .y_i,
    .vld_o(vld_s[0]), .x_o(x_s[0]), .y_o(y_s[0]), .tag_o(tag_s[0])
  );
  assign z_s[0] = '0;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    rp_stage #(.D_W(D_W), .Z_W(Z_W), .IDX(i)) i_stage (
      .clk_i, .rst_ni,
      .vld_i(vld_s[i]),   .x_i(x_s[i]),   .y_i(y_s[i]),
      .z_i(z_s[i]),       .tag_i(tag_s[i]),
      .vld_o(vld_s[i+1]), .x_o(x_s[i+1]), .y_o(y_s[i+1]),
      .z_o(z_s[i+1]),     .tag_o(tag_s[i+1])
    );
  end

  rp_finish #(.D_W(D_W), .Z_W(Z_W), .ANG_W(ANG_W), .MAG_W(MAG_W), .LSB_G(LSB_G)) i_finish (
    .clk_i, .rst_ni,
    .vld_i(vld_s[STAGES]), .x_i(x_s[STAGES]), .y_i(y_s[STAGES]),
    .z_i(z_s[STAGES]),     .tag_i(tag_s[STAGES]),
    .vld_o, .mag_o, .ang_o
  );

  // cycles since reset, saturating at the latency
  logic [CNT_W-1:0] since_rst;
  always_ff @(posedge clk_i) begin
    if (!rst_ni)                      since_rst <= '0;
    else if (since_rst < CNT_W'(LAT)) since_rst <= since_rst + 1'b1;
  end

  assert_no_early_out_R2: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (since_rst >= CNT_W'(LAT))
  ) else $error("result before pipeline filled");

endmodule

// File: tb/test_rect2polar.sv
module test_rect2polar;

  localparam int IN_W   = 16;
  localparam int STAGES = 16;
  localparam int ANG_W  = 16;
  localparam int LAT    = STAGES + 2;
  localparam int MAG_W  = IN_W + 1;
  localparam real TWO_PI = 6.283185307179586;

  logic                    clk;
  logic                    rst_ni;
  logic                    vld_i;
  logic signed [IN_W-1:0]  x_i, y_i;
  logic                    vld_o;
  logic [MAG_W-1:0]        mag_o;
  logic signed [ANG_W-1:0] ang_o;

  rect2polar #(.IN_W(IN_W), .STAGES(STAGES), .ANG_W(ANG_W)) i_rect2polar (
    .clk_i(clk), .rst_ni, .vld_i, .x_i, .y_i, .vld_o, .mag_o, .ang_o
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int     checks = 0;
  int     errors = 0;
  int     n_in   = 0;
  int     n_out  = 0;
  longint cyc    = 0;
  int     qx[$];
  int     qy[$];
  longint qc[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0f expected=%0f", req, what, act, exp);
    end
  endtask

  // output monitor
  int     ex, ey;
  longint ec;
  real    em, ea, da, tol;
  string  tag;
  always @(negedge clk) begin
    if (rst_ni && vld_o) begin
      n_out++;
      if (qx.size() == 0) begin
        check(1'b0, "R9", "result without sample", 1.0, 0.0);
      end else begin
        ex = qx.pop_front();
        ey = qy.pop_front();
        ec = qc.pop_front();
        check(cyc == ec + LAT, "R2", "latency", real'(cyc - ec), real'(LAT));
        check(mag_o <= (3 << (MAG_W - 3)), "R6", "mag bound",
              real'(mag_o), real'(3 << (MAG_W - 3)));
        if (ex == 0 && ey == 0) begin
          check(mag_o == 0, "R7", "zero mag", real'(mag_o), 0.0);
          check(ang_o == 0, "R7", "zero ang", real'(ang_o), 0.0);
        end else begin
          em = $sqrt(real'(ex) * real'(ex) + real'(ey) * real'(ey));
          check((real'(mag_o) - em <= 3.0) && (em - real'(mag_o) <= 3.0),
                "R4", "magnitude", real'(mag_o), em);
          ea = $atan2(real'(ey), real'(ex)) * (2.0 ** ANG_W) / TWO_PI;
          da = real'(ang_o) - ea;
          if (da >  (2.0 ** (ANG_W - 1))) da = da - (2.0 ** ANG_W);
          if (da < -(2.0 ** (ANG_W - 1))) da = da + (2.0 ** ANG_W);
          tol = 4.0 + (2.0 ** (ANG_W + 1)) / (TWO_PI * em);
          if (ex == 0 || ey == 0) tag = "R8";
          else if (ex < 0)        tag = "R3";
          else                    tag = "R5";
          check(da <= tol && da >= -tol, tag, "angle", real'(ang_o), ea);
        end
      end
    end
  end

  task automatic send(input logic signed [IN_W-1:0] x, input logic signed [IN_W-1:0] y);
    @(posedge clk);
    #1;
    vld_i = 1'b1;
    x_i   = x;
    y_i   = y;
    qx.push_back(int'(x));
    qy.push_back(int'(y));
    qc.push_back(cyc);
    n_in++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
      vld_i = 1'b0;
      x_i   = IN_W'($urandom());  // junk must be ignored (R9)
      y_i   = IN_W'($urandom());
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int unsigned seed_init;
  initial begin
    seed_init = $urandom(32'd9137);
    rst_ni = 1'b0;
    vld_i  = 1'b0;
    x_i    = 16'sd1234;
    y_i    = -16'sd77;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(vld_o == 1'b0, "R1", "vld_o in reset", real'(vld_o), 0.0);
    check(mag_o == '0,   "R1", "mag_o in reset", real'(mag_o), 0.0);
    check(ang_o == '0,   "R1", "ang_o in reset", real'(ang_o), 0.0);
    rst_ni = 1'b1;
    idle(LAT + 4);
    check(vld_o == 1'b0, "R9", "no output when idle", real'(vld_o), 0.0);

    // directed corners, back to back: zero override next to reflections
    send(16'sd0, 16'sd0);
    send(-16'sd20000, 16'sd5);
    send(16'sd0, 16'sd0);
    send(-16'sd20000, -16'sd5);
    send(-16'sd32768, -16'sd32768);
    send(16'sd0, 16'sd0);
    send(16'sd32767, 16'sd32767);
    send(-16'sd32768, 16'sd0);
    send(16'sd32767, 16'sd0);
    send(16'sd0, 16'sd20000);
    send(16'sd0, -16'sd20000);
    send(-16'sd32768, 16'sd32767);
    send(16'sd32767, -16'sd32768);
    send(16'sd256, 16'sd256);
    send(-16'sd3000, 16'sd4000);
    send(-16'sd3000, -16'sd4000);
    idle(5);
    send(16'sd0, 16'sd0);
    idle(LAT + 2);

    // dense random burst
    for (int k = 0; k < 400; k++) send(IN_W'($urandom()), IN_W'($urandom()));
    // random with gaps and occasional corners
    for (int k = 0; k < 400; k++) begin
      if (($urandom() % 16) == 0) send(16'sd0, 16'sd0);
      else if (($urandom() % 16) == 0) send(-IN_W'($urandom() % 30000) - 16'sd1, 16'sd0);
      else send(IN_W'($urandom()), IN_W'($urandom()));
      if ($urandom() % 2) idle(1 + ($urandom() % 3));
    end
    idle(LAT + 5);

    check(qx.size() == 0, "R9", "pending samples", real'(qx.size()), 0.0);
    check(n_out == n_in, "R9", "result count", real'(n_out), real'(n_in));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule